// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block is an SPI master in mode 0 that loads a downstream FPGA through that device's slave SPI configuration port. A single `start_i` pulse runs a fixed script with no further help from the host. The block reads the device identity and accepts only two known values. It then sends refresh, write-enable and erase commands and polls the status word until the device reports erased. Next it streams the bitstream inside one chip-select frame, sends write-disable and reads status one last time to decide whether the device reached the configured state.

The bitstream arrives on a byte-stream input with a valid/ready handshake. Ready is raised only while the burst frame is open, and the burst ends on the byte that carries `img_last_i`. If `img_empty_i` is set together with `start_i`, the image has no bytes: the run is refused at once and no SPI traffic is generated. `busy_o` is high from start until the verdict. The verdict is then held on `done_o`, `err_o` and `err_code_o` until the next start.

The control is one state machine with these states:
- `S_IDLE`: waiting for start.
- `S_OPEN`: chip select drops and the opcode byte is launched.
- `S_XFER`: pad and response bytes.
- `S_BURST`: waiting for an image byte.
- `S_BURST_X`: an image byte is shifting.
- `S_GAP`: chip select is high between frames.
- `S_EVAL`: the result of a command is judged and the next script step is picked.
- `S_WAIT`: the pause between status polls.

The transitions are:
- IDLE→OPEN on start.
- OPEN→XFER.
- XFER→BURST after the burst header.
- XFER→GAP after the last byte of a command.
- BURST→BURST_X when a byte is accepted.
- BURST_X→BURST, or BURST_X→GAP on the last byte.
- GAP→EVAL.
- EVAL→OPEN for the next step.
- EVAL→WAIT for a repeat poll.
- EVAL→IDLE when the run finishes.
- WAIT→OPEN.

The script steps, in order, are identity, first status, refresh, write enable, erase, poll, burst, write disable and final status.

Top module: `spi_cfg_seq`

## Requirements
- R1: SPI runs in mode 0. SCLK idles low, MOSI changes only while SCLK is low, and bytes go out MSB first. A write command frame is its opcode followed by three 0x00 bytes (4 bytes in all). A read frame is the opcode, seven 0x00 bytes sent, and the 32-bit response clocked in during bytes 5 to 8.
- R2: Opcodes: read identity 0x07, read status 0x09, erase 0x70, refresh 0x71, write enable 0x4A, write disable 0x4F, incrementing write 0x41.
- R3: The identity response must be 0xC2088080 or 0xC2048080. Any other value ends the run with error code 2 after the identity frame, with no further frames and no image byte accepted.
- R4: After a good identity, frames follow in this order: status read, refresh, write enable, erase, status polls, burst, write disable, final status read.
- R5: Polling repeats a status read until the word equals 0x00010000 exactly. Between polls chip select stays high for at least POLL_INTERVAL clock cycles. After POLL_LIMIT polls without that value the run ends with error code 3 and no burst.
- R6: The burst is a single chip-select frame of 0x41, 0xFF, 0xFF, 0xFF and then every image byte in order. It closes after the byte flagged last.
- R7: If bit 14 (mask 0x00004000) of the final status word is set, the run ends with error code 0 and `err_o` low. Otherwise it ends with error code 4.
- R8: `start_i` together with `img_empty_i` ends the run with error code 1 on the next cycle, and chip select stays high.
- R9: Between two frames of one run, chip select stays high for at least two SCLK periods (4·HALF_DIV clock cycles).
- R10: `img_ready_o` is high only inside the burst frame, after the four header bytes.
- R11: The response word is built in wire order: the first received byte is bits 31:24.
- R12: `busy_o` is high from the cycle after start until the verdict. `done_o` falls on start and is then held high, with `err_o` and `err_code_o`, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a configuration run (taken when idle) |
| img_empty_i | input | 1 | Image has no bytes; sampled with start |
| img_data_i | input | 8 | Bitstream byte |
| img_valid_i | input | 1 | Bitstream byte valid |
| img_last_i | input | 1 | Marks the final bitstream byte |
| img_ready_o | output | 1 | Byte accepted when high with valid |
| spi_sclk_o | output | 1 | SPI clock, mode 0 |
| spi_mosi_o | output | 1 | SPI data to the device |
| spi_miso_i | input | 1 | SPI data from the device |
| spi_cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Verdict available |
| err_o | output | 1 | Verdict is a failure |
| err_code_o | output | 3 | 0 ok, 1 empty image, 2 unknown identity, 3 erase timeout, 4 not configured |

## Verification
The bench builds the block with HALF_DIV=2, POLL_INTERVAL=20 and POLL_LIMIT=4. With these values a frame is a few hundred cycles and the production 10 ms poll spacing shrinks to 20 cycles. The erase timeout is therefore reached after four polls, so the timeout path, the exact-match rule (a near-miss word 0x00010001) and the minimum poll spacing can all be tested in short runs. The small divider also makes the two-SCLK chip-select gap a short, exact bound of 8 cycles.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam logic [7:0] OP_RD_ID   = 8'h07;
    localparam logic [7:0] OP_RD_STAT = 8'h09;
    localparam logic [7:0] OP_ERASE   = 8'h70;
    localparam logic [7:0] OP_REFRESH = 8'h71;
    localparam logic [7:0] OP_WR_EN   = 8'h4A;
    localparam logic [7:0] OP_WR_DIS  = 8'h4F;
    localparam logic [7:0] OP_WR_INC  = 8'h41;

    localparam logic [31:0] DEV_ID_A    = 32'hC208_8080;
    localparam logic [31:0] DEV_ID_B    = 32'hC204_8080;
    localparam logic [31:0] STAT_ERASED = 32'h0001_0000;
    localparam logic [31:0] STAT_CONFIG = 32'h0000_4000;

    typedef enum logic [3:0] {
        STP_ID, STP_STAT0, STP_REFRESH, STP_WEN, STP_ERASE,
        STP_POLL, STP_BURST, STP_WDIS, STP_FINAL
    } step_t;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_EMPTY   = 3'd1,
        ERR_BADID   = 3'd2,
        ERR_TIMEOUT = 3'd3,
        ERR_NOTDONE = 3'd4
    } err_t;

    function automatic logic [7:0] opcode_of(step_t s);
        unique case (s)
            STP_ID:      return OP_RD_ID;
            STP_REFRESH: return OP_REFRESH;
            STP_WEN:     return OP_WR_EN;
            STP_ERASE:   return OP_ERASE;
            STP_BURST:   return OP_WR_INC;
            STP_WDIS:    return OP_WR_DIS;
            default:     return OP_RD_STAT;
        endcase
    endfunction

    function automatic logic is_read(step_t s);
        return (s == STP_ID) || (s == STP_STAT0) || (s == STP_POLL) || (s == STP_FINAL);
    endfunction

endpackage

// File: rtl/spi_cfg_byte_eng.sv
module spi_cfg_byte_eng #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    output logic [7:0] rx_o,
    output logic       done_o,
    output logic       sclk_o,
    output logic       mosi_o,
    input  logic       miso_i
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    logic          active_q;
    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic          sclk_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (go_i) begin
                    active_q <= 1'b1;
                    sh_q     <= tx_i;
                    div_q    <= '0;
                    bit_q    <= '0;
                    sclk_q   <= 1'b0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso_i};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign sclk_o = sclk_q;
    assign mosi_o = active_q & sh_q[7];
    assign rx_o   = rx_q;
    assign done_o = done_q;

    // R1
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !sclk_o);
    // R1
    mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(mosi_o));

endmodule

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq
    import spi_cfg_pkg::*;
#(
    parameter int HALF_DIV      = 4,
    parameter int POLL_INTERVAL = 1000000,
    parameter int POLL_LIMIT    = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       img_empty_i,
    input  logic [7:0] img_data_i,
    input  logic       img_valid_i,
    input  logic       img_last_i,
    output logic       img_ready_o,
    output logic       spi_sclk_o,
    output logic       spi_mosi_o,
    input  logic       spi_miso_i,
    output logic       spi_cs_n_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [2:0] err_code_o
);
    localparam int GAP_CYC = 4 * HALF_DIV;
    localparam int GW = $clog2(GAP_CYC + 2);
    localparam int WW = $clog2(POLL_INTERVAL + 1);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_OPEN, S_XFER, S_BURST, S_BURST_X, S_GAP, S_EVAL, S_WAIT
    } state_t;

    state_t        state_q;
    step_t         step_q;
    logic [2:0]    idx_q;
    logic [31:0]   resp_q;
    logic [GW-1:0] gap_q;
    logic [WW-1:0] wait_q;
    logic [PW-1:0] poll_q;
    logic          go_q;
    logic [7:0]    tx_q;
    logic          last_q;
    logic          done_q;
    err_t          err_q;

    logic       eng_done;
    logic [7:0] eng_rx;
    logic       cs_act;

    spi_cfg_byte_eng #(.HALF_DIV(HALF_DIV)) eng_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go_q),
        .tx_i   (tx_q),
        .rx_o   (eng_rx),
        .done_o (eng_done),
        .sclk_o (spi_sclk_o),
        .mosi_o (spi_mosi_o),
        .miso_i (spi_miso_i)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= STP_ID;
            idx_q   <= '0;
            resp_q  <= '0;
            gap_q   <= '0;
            wait_q  <= '0;
            poll_q  <= '0;
            go_q    <= 1'b0;
            tx_q    <= '0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            go_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        done_q <= 1'b0;
                        err_q  <= ERR_NONE;
                        if (img_empty_i) begin
                            done_q <= 1'b1;
                            err_q  <= ERR_EMPTY;
                        end else begin
                            step_q  <= STP_ID;
                            poll_q  <= '0;
                            state_q <= S_OPEN;
                        end
                    end
                end
                S_OPEN: begin
                    tx_q    <= opcode_of(step_q);
                    go_q    <= 1'b1;
                    idx_q   <= '0;
                    state_q <= S_XFER;
                end
                S_XFER: begin
                    if (eng_done) begin
                        if (is_read(step_q) && idx_q[2])
                            resp_q <= {resp_q[23:0], eng_rx};
                        if (step_q == STP_BURST && idx_q == 3'd3) begin
                            state_q <= S_BURST;
                        end else if ((!is_read(step_q) && idx_q == 3'd3) || idx_q == 3'd7) begin
                            gap_q   <= '0;
                            state_q <= S_GAP;
                        end else begin
                            idx_q <= idx_q + 3'd1;
                            tx_q  <= (step_q == STP_BURST) ? 8'hFF : 8'h00;
                            go_q  <= 1'b1;
                        end
                    end
                end
                S_BURST: begin
                    if (img_valid_i) begin
                        tx_q    <= img_data_i;
                        last_q  <= img_last_i;
                        go_q    <= 1'b1;
                        state_q <= S_BURST_X;
                    end
                end
                S_BURST_X: begin
                    if (eng_done) begin
                        if (last_q) begin
                            gap_q   <= '0;
                            state_q <= S_GAP;
                        end else begin
                            state_q <= S_BURST;
                        end
                    end
                end
                S_GAP: begin
                    gap_q <= gap_q + GW'(1);
                    if (gap_q == GW'(GAP_CYC - 1))
                        state_q <= S_EVAL;
                end
                S_WAIT: begin
                    wait_q <= wait_q + WW'(1);
                    if (wait_q == WW'(POLL_INTERVAL - 1))
                        state_q <= S_OPEN;
                end
                S_EVAL: begin
                    state_q <= S_OPEN;
                    unique case (step_q)
                        STP_ID: begin
                            if (resp_q == DEV_ID_A || resp_q == DEV_ID_B) begin
                                step_q <= STP_STAT0;
                            end else begin
                                done_q  <= 1'b1;
                                err_q   <= ERR_BADID;
                                state_q <= S_IDLE;
                            end
                        end
                        STP_STAT0:   step_q <= STP_REFRESH;
                        STP_REFRESH: step_q <= STP_WEN;
                        STP_WEN:     step_q <= STP_ERASE;
                        STP_ERASE:   step_q <= STP_POLL;
                        STP_POLL: begin
                            if (resp_q == STAT_ERASED) begin
                                step_q <= STP_BURST;
                            end else if (poll_q == PW'(POLL_LIMIT - 1)) begin
                                done_q  <= 1'b1;
                                err_q   <= ERR_TIMEOUT;
                                state_q <= S_IDLE;
                            end else begin
                                poll_q  <= poll_q + PW'(1);
                                wait_q  <= '0;
                                state_q <= S_WAIT;
                            end
                        end
                        STP_BURST: step_q <= STP_WDIS;
                        STP_WDIS:  step_q <= STP_FINAL;
                        STP_FINAL: begin
                            done_q  <= 1'b1;
                            err_q   <= ((resp_q & STAT_CONFIG) != 32'd0) ? ERR_NONE : ERR_NOTDONE;
                            state_q <= S_IDLE;
                        end
                        default: state_q <= S_IDLE;
                    endcase
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cs_act      = (state_q == S_OPEN) || (state_q == S_XFER) ||
                      (state_q == S_BURST) || (state_q == S_BURST_X);
        spi_cs_n_o  = !cs_act;
        img_ready_o = (state_q == S_BURST);
        busy_o      = (state_q != S_IDLE);
        done_o      = done_q;
        err_o       = done_q && (err_q != ERR_NONE);
        err_code_o  = err_q;
    end

    logic [GW-1:0] hi_cnt_q;
    logic          framed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
            framed_q <= 1'b0;
        end else begin
            if (!busy_o)          framed_q <= 1'b0;
            else if (!spi_cs_n_o) framed_q <= 1'b1;
            if (!spi_cs_n_o)                             hi_cnt_q <= '0;
            else if (hi_cnt_q != GW'(GAP_CYC + 1))       hi_cnt_q <= hi_cnt_q + GW'(1);
        end
    end

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (framed_q && $fell(spi_cs_n_o)) |-> (hi_cnt_q >= GW'(GAP_CYC)));
    // R10
    ready_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready_o |-> (step_q == STP_BURST && idx_q == 3'd3));
    // R8
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && img_empty_i) |=> (!busy_o && spi_cs_n_o && err_code_o == 3'd1 && done_o));
    // R3
    badid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVAL && step_q == STP_ID && resp_q != DEV_ID_A && resp_q != DEV_ID_B)
        |=> (done_o && err_code_o == 3'd2 && spi_cs_n_o));
    // R5
    poll_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (poll_q < PW'(POLL_LIMIT)));
    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/spi_cfg_seq_tb_top.sv
module spi_cfg_seq_tb_top;
    localparam int HALF = 2;
    localparam int PINT = 20;
    localparam int PLIM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, img_empty = 1'b0;
    logic [7:0] img_data = '0;
    logic img_valid = 1'b0, img_last = 1'b0;
    logic img_ready, sclk, mosi, miso, cs_n, busy, done, err;
    logic [2:0] err_code;

    always #4 clk = ~clk;

    spi_cfg_seq #(.HALF_DIV(HALF), .POLL_INTERVAL(PINT), .POLL_LIMIT(PLIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .img_empty_i(img_empty),
        .img_data_i(img_data), .img_valid_i(img_valid), .img_last_i(img_last),
        .img_ready_o(img_ready), .spi_sclk_o(sclk), .spi_mosi_o(mosi),
        .spi_miso_i(miso), .spi_cs_n_o(cs_n), .busy_o(busy), .done_o(done),
        .err_o(err), .err_code_o(err_code)
    );

    int n_chk = 0, n_fail = 0;
    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard queues: expected bytes, frame lengths, frame tags
    byte unsigned exp_b[$];
    int           exp_len[$];
    string        exp_tag[$];

    // device model
    int unsigned  cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;
    int           bitpos = 0;
    logic [7:0]   rxsh = '0;
    logic [31:0]  resp_word = '0;
    byte unsigned cur[$];
    logic [31:0]  id_word = '0, final_word = '0;
    int           erase_after = 0, poll_n = 0, frames_seen = 0;
    bit           saw_erase = 0, saw_wdis = 0, cs_prev = 1'b1;
    int unsigned  rise_cyc = 0, cur_gap = 0, min_gap = 32'hFFFF, min_poll_gap = 32'hFFFF;
    byte unsigned last_op = 0;

    assign miso = (!cs_n && bitpos >= 32 && bitpos < 64) ? resp_word[63 - bitpos] : 1'b0;

    task automatic pick_resp(input byte unsigned op);
        resp_word = 32'h0;
        case (op)
            8'h07: resp_word = id_word;
            8'h09: begin
                if (saw_wdis) resp_word = final_word;
                else if (saw_erase) begin
                    poll_n++;
                    resp_word = (poll_n >= erase_after) ? 32'h0001_0000 : 32'h0001_0001;
                end
            end
            8'h70: saw_erase = 1;
            8'h4F: saw_wdis = 1;
            default: ;
        endcase
    endtask

    task automatic frame_end();
        bit ok;
        int n;
        string tag;
        frames_seen++;
        rise_cyc = cyc;
        last_op = (cur.size() > 0) ? cur[0] : 8'h00;
        if (exp_len.size() == 0) begin
            check(1'b0, "R4", "unexpected frame, opcode", 64'(last_op), 64'h0);
        end else begin
            n = exp_len.pop_front();
            tag = exp_tag.pop_front();
            ok = (cur.size() == n);
            for (int i = 0; i < n; i++) begin
                byte unsigned e;
                e = exp_b.pop_front();
                if (i >= cur.size() || cur[i] != e) ok = 0;
            end
            check(ok, tag, "frame content, first byte / length",
                  {32'(cur.size() > 0 ? cur[0] : 0), 32'(cur.size())}, 64'(n));
        end
    endtask

    always @(posedge sclk or posedge cs_n or negedge cs_n) begin
        if (cs_n !== cs_prev) begin
            cs_prev = cs_n;
            if (cs_n) frame_end();
            else begin
                cur.delete();
                bitpos = 0;
                cur_gap = cyc - rise_cyc;
                if (frames_seen > 0 && cur_gap < min_gap) min_gap = cur_gap;
            end
        end else if (!cs_n && sclk) begin
            rxsh = {rxsh[6:0], mosi};
            bitpos++;
            if (bitpos % 8 == 0) cur.push_back(rxsh);
            if (bitpos == 8) begin
                pick_resp(rxsh);
                if (rxsh == 8'h09 && last_op == 8'h09 && cur_gap < min_poll_gap)
                    min_poll_gap = cur_gap;
            end
        end
    end

    // image driver
    byte unsigned img_q[$];
    bit acc_prev = 0, ready_bad = 0;
    int stall_ctr = 0;
    always @(negedge clk) begin
        if (acc_prev && img_q.size() > 0) void'(img_q.pop_front());
        stall_ctr++;
        img_valid = (img_q.size() > 0) && (stall_ctr % 3 != 2);
        img_data  = (img_q.size() > 0) ? img_q[0] : 8'h00;
        img_last  = (img_q.size() == 1);
        if (img_ready && (cs_n || cur.size() < 4 || cur[0] != 8'h41)) ready_bad = 1;
        acc_prev = img_ready && img_valid;
    end

    task automatic push_cmd(input byte unsigned op, input bit rd, input string tag);
        exp_b.push_back(op);
        for (int i = 0; i < (rd ? 7 : 3); i++) exp_b.push_back(8'h00);
        exp_len.push_back(rd ? 8 : 4);
        exp_tag.push_back(tag);
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic do_run(input logic [31:0] id, input int ea, input logic [31:0] fin,
                          input int nbytes, input logic [2:0] code, input string req);
        bit ok;
        byte unsigned d;
        id_word = id; erase_after = ea; final_word = fin;
        poll_n = 0; saw_erase = 0; saw_wdis = 0; ready_bad = 0;
        min_gap = 32'hFFFF; min_poll_gap = 32'hFFFF;
        push_cmd(8'h07, 1, "R2 identity read");
        if (code != 3'd2) begin
            push_cmd(8'h09, 1, "R1 first status read");
            push_cmd(8'h71, 0, "R4 refresh");
            push_cmd(8'h4A, 0, "R4 write enable");
            push_cmd(8'h70, 0, "R4 erase");
            for (int p = 0; p < ((code == 3'd3) ? PLIM : ea); p++)
                push_cmd(8'h09, 1, "R5 poll");
        end
        for (int i = 0; i < nbytes; i++) img_q.push_back(8'((i * 37 + 5) & 255));
        if (code != 3'd2 && code != 3'd3) begin
            exp_b.push_back(8'h41);
            for (int i = 0; i < 3; i++) exp_b.push_back(8'hFF);
            for (int i = 0; i < nbytes; i++) begin
                d = 8'((i * 37 + 5) & 255);
                exp_b.push_back(d);
            end
            exp_len.push_back(4 + nbytes);
            exp_tag.push_back("R6 burst");
            push_cmd(8'h4F, 0, "R4 write disable");
            push_cmd(8'h09, 1, "R4 final status");
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy && !done, "R12", "busy/done after start", {busy, done}, 2'b10);
        wait_done(ok);
        check(ok, "R12", "run finished", ok, 1);
        check(err_code == code && err == (code != 3'd0), req, "error code",
              {err, err_code}, {code != 3'd0, code});
        check(exp_len.size() == 0, "R4", "frames outstanding", exp_len.size(), 0);
        check(!ready_bad, "R10", "ready outside burst payload", ready_bad, 0);
        check(min_gap >= 4 * HALF, "R9", "min chip-select gap", min_gap, 4 * HALF);
        if (code == 3'd3 || ea > 1)
            check(min_poll_gap >= PINT && min_poll_gap != 32'hFFFF, "R5", "poll spacing",
                  min_poll_gap, PINT);
        if (code == 3'd2 || code == 3'd3)
            check(img_q.size() == nbytes, "R3", "image bytes untouched", img_q.size(), nbytes);
        img_q.delete();
        exp_b.delete(); exp_len.delete(); exp_tag.delete();
        repeat (10) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        check(1'b0, "R12", "watchdog expired", 0, 1);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int f0;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && cs_n && !sclk && !done && !err && !img_ready, "R12", "reset state",
              {busy, cs_n, sclk, done, err, img_ready}, 6'b010000);

        // R8 empty image
        f0 = frames_seen;
        img_empty = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0; img_empty = 1'b0;
        check(done && err && err_code == 3'd1 && !busy, "R8", "empty image verdict",
              {done, err, err_code}, {2'b11, 3'd1});
        repeat (40) @(negedge clk);
        check(frames_seen == f0 && cs_n, "R8", "no SPI traffic", frames_seen - f0, 0);

        // R3 unknown identity
        do_run(32'hC208_8081, 1, 32'h0000_4000, 4, 3'd2, "R3");
        // R7 R11 good identity A, two polls, DONE set
        do_run(32'hC208_8080, 2, 32'h0000_4000, 5, 3'd0, "R7 R11");
        // R7 identity B, DONE clear with other bits set
        do_run(32'hC204_8080, 1, 32'hFFFF_BFFF, 3, 3'd4, "R7");
        // R5 erase never reported (near-miss word) -> timeout
        do_run(32'hC204_8080, 100, 32'h0000_4000, 3, 3'd3, "R5");
        // R6 single-byte image, three polls
        do_run(32'hC204_8080, 3, 32'h0001_4000, 1, 3'd0, "R6 R7");

        // R12 next start clears done
        img_empty = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0; img_empty = 1'b0;
        check(done && err_code == 3'd1, "R12", "verdict replaced by new run", err_code, 1);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule